// File: doc/BRIEF.md
# Prescaled Time-Base Timer

This block is the time-base counter of a small 4-bit controller core. It divides the primary clock by four to form an instruction-cycle tick, and on that tick a 2-bit prescaler advances an 8-bit up counter once every four instruction cycles. Together they form a 10-bit timebase. A wrap of the counter from its all-ones value sets a sticky overflow flag. The tick is derived only from the primary clock, so the timebase keeps its rate whatever clock the core itself runs from.

The core drives commands during tick cycles. A load writes the accumulator nibble into the counter's upper half and the memory nibble into its lower half, and clears the prescaler. A read returns both halves. A test reports a skip and clears the flag if the flag is set. An idle request stalls the core until the next counter overflow, and then a one-cycle wake pulse is issued. The instruction decoder and the core datapath are outside this block.

Top module: `tbt_timebase`

## Requirements
- R1: `tick_o` is high for one clock in every four. After reset is released it is first high in the third clock, counted from the first rising edge after release.
- R2: The 2-bit prescaler counts ticks. The counter advances by one on every fourth tick after the prescaler was last cleared.
- R3: A load on a tick sets counter bits 7:4 to `acc_i` and bits 3:0 to `mem_i`, and clears the prescaler. The first advance after a load happens on the fourth tick that follows the load tick.
- R4: A load whose `acc_i` bit 3 (counter bit 7) is 1 sets the overflow flag in the same edge.
- R5: An advance from 0xFF wraps the counter to 0x00 and sets the overflow flag.
- R6: A test on a tick raises `skip_o` for one clock after that edge and clears the flag when the flag is set. When the flag is clear, `skip_o` stays 0 and the flag stays clear.
- R7: When an overflow and a test fall on the same tick, the flag stays set.
- R8: A read on a tick places counter bits 7:4 on `rd_acc_o` and bits 3:0 on `rd_mem_o`. The value taken is the one from before that edge's update, and it is held until the next read.
- R9: A synchronous reset clears the counter, the prescaler, the flag, the idle state and all outputs.
- R10: An idle request raises `stall_o` from the next clock. The counter keeps running. On the next overflow `stall_o` falls and `wake_o` is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_o | output | 1 | Instruction-cycle tick, one clock in four |
| load_i | input | 1 | Load command, sampled on tick |
| acc_i | input | 4 | Accumulator nibble for the counter's upper half |
| mem_i | input | 4 | Memory nibble for the counter's lower half |
| read_i | input | 1 | Read command, sampled on tick |
| test_i | input | 1 | Test-and-clear command, sampled on tick |
| idle_i | input | 1 | Idle-until-overflow request, sampled on tick |
| rd_acc_o | output | 4 | Counter bits 7:4 from the last read |
| rd_mem_o | output | 4 | Counter bits 3:0 from the last read |
| skip_o | output | 1 | One-clock skip indication after a test |
| stall_o | output | 1 | Core stall while idle |
| wake_o | output | 1 | One-clock pulse that ends idle |

## Verification
Read data and skip appear one clock after the tick edge that sampled the command. The bench drives each command on the falling edge inside a tick cycle and samples on the next falling edge. Counter advances are due a whole number of ticks after a load: the fourth tick after the load is the first advance. The bench counts ticks to place reads and tests just before and just after that edge. The wake pulse is counted in clocks from the idle request: it is due exactly 40 clocks later for a counter that starts at three below a wrap, and the bench checks the clocks on either side of that one.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CNT_W = 2 * NIB_W;

  typedef struct packed {
    logic load;
    logic read;
    logic test;
    logic idle;
  } tbt_cmd_t;
endpackage

// File: rtl/tbt_cycle_div.sv
module tbt_cycle_div #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] LAST_PH = {DIV_W{1'b1}} - 1'b1;

  logic [DIV_W-1:0] phase_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      tick_q  <= (phase_q == LAST_PH);
    end
  end

  assign tick_o = tick_q;

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/tbt_prescale.sv
module tbt_prescale #(
  parameter int unsigned PRE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (tick_i) begin
      if (clr_i) pre_q <= '0;
      else       pre_q <= pre_q + 1'b1;
    end
  end

  assign adv_o = tick_i && !clr_i && (pre_q == PRE_MAX);

  // R3
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && clr_i) |=> (pre_q == '0));
  // R2
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pre_q));
endmodule

// File: rtl/tbt_count.sv
module tbt_count #(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [NIB_W-1:0]   hi_i,
  input  logic [NIB_W-1:0]   lo_i,
  input  logic               adv_i,
  output logic [2*NIB_W-1:0] cnt_o,
  output logic               ovf_o
);
  localparam int unsigned CNT_W = 2 * NIB_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= {hi_i, lo_i};
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = adv_i && !load_i && (&cnt_q);

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past({hi_i, lo_i})));
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (cnt_q == '0));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tbt_status.sv
module tbt_status (
  input  logic clk,
  input  logic rst,
  input  logic ovf_i,
  input  logic load_msb_i,
  input  logic test_i,
  input  logic idle_i,
  output logic skip_o,
  output logic stall_o,
  output logic wake_o
);
  logic flag_q, skip_q, idle_q, wake_q;
  logic flag_set, flag_clr, idle_any;

  assign flag_set = ovf_i || load_msb_i;
  assign flag_clr = test_i && flag_q;
  assign idle_any = idle_q || idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      skip_q <= 1'b0;
      idle_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      skip_q <= flag_clr;
      idle_q <= idle_any && !ovf_i;
      wake_q <= idle_any && ovf_i;
    end
  end

  assign skip_o  = skip_q;
  assign stall_o = idle_q;
  assign wake_o  = wake_q;

  // R7
  ovf_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_i |=> flag_q);
  // R4
  load_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load_msb_i |=> flag_q);
  // R6
  no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (test_i && !flag_q) |=> !skip_q);
  // R10
  wake_end_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (!idle_q && $past(idle_any)));
  // R10
  wake_once_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
  import tbt_pkg::*;
#(
  parameter int unsigned DIV_W = 2,
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick_o,
  input  logic             load_i,
  input  logic [NIB_W-1:0] acc_i,
  input  logic [NIB_W-1:0] mem_i,
  input  logic             read_i,
  input  logic             test_i,
  input  logic             idle_i,
  output logic [NIB_W-1:0] rd_acc_o,
  output logic [NIB_W-1:0] rd_mem_o,
  output logic             skip_o,
  output logic             stall_o,
  output logic             wake_o
);
  logic             tick;
  tbt_cmd_t         cmd;
  logic             adv, ovf;
  logic [CNT_W-1:0] cnt;
  logic [NIB_W-1:0] rd_acc_q, rd_mem_q;

  tbt_cycle_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  always_comb begin
    cmd.load = tick && load_i;
    cmd.read = tick && read_i;
    cmd.test = tick && test_i;
    cmd.idle = tick && idle_i;
  end

  tbt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick), .clr_i(cmd.load), .adv_o(adv)
  );

  tbt_count #(.NIB_W(NIB_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(cmd.load), .hi_i(acc_i), .lo_i(mem_i),
    .adv_i(adv), .cnt_o(cnt), .ovf_o(ovf)
  );

  tbt_status u_stat (
    .clk(clk), .rst(rst), .ovf_i(ovf), .load_msb_i(cmd.load && acc_i[NIB_W-1]),
    .test_i(cmd.test), .idle_i(cmd.idle),
    .skip_o(skip_o), .stall_o(stall_o), .wake_o(wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_acc_q <= '0;
      rd_mem_q <= '0;
    end else if (cmd.read) begin
      rd_acc_q <= cnt[CNT_W-1:NIB_W];
      rd_mem_q <= cnt[NIB_W-1:0];
    end
  end

  assign tick_o   = tick;
  assign rd_acc_o = rd_acc_q;
  assign rd_mem_o = rd_mem_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.read |=> ($stable(rd_acc_o) && $stable(rd_mem_o)));
  // R6
  skip_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> $past(tick));
endmodule

// File: tb/tbt_timebase_test.sv
module tbt_timebase_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_o;
  logic       load_i = 1'b0, read_i = 1'b0, test_i = 1'b0, idle_i = 1'b0;
  logic [3:0] acc_i = '0, mem_i = '0;
  logic [3:0] rd_acc_o, rd_mem_o;
  logic       skip_o, stall_o, wake_o;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tbt_timebase uut (
    .clk(clk), .rst(rst), .tick_o(tick_o), .load_i(load_i), .acc_i(acc_i),
    .mem_i(mem_i), .read_i(read_i), .test_i(test_i), .idle_i(idle_i),
    .rd_acc_o(rd_acc_o), .rd_mem_o(rd_mem_o), .skip_o(skip_o),
    .stall_o(stall_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive one command in the next tick cycle; returns at the following negedge.
  task automatic issue(input logic ld, input logic [7:0] val,
                       input logic rd, input logic ts, input logic id);
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    load_i = ld; acc_i = val[7:4]; mem_i = val[3:0];
    read_i = rd; test_i = ts; idle_i = id;
    @(negedge clk);
    load_i = 0; read_i = 0; test_i = 0; idle_i = 0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) issue(0, 8'h00, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (5) @(negedge clk);
    rst = 0;
  endtask

  task automatic test_reset_state();
    do_reset();
    check("R9 skip", skip_o, 0);
    check("R9 stall", stall_o, 0);
    check("R9 rd", {rd_acc_o, rd_mem_o}, 0);
    @(negedge clk); check("R1 tick k1", tick_o, 0);
    @(negedge clk); check("R1 tick k2", tick_o, 0);
    @(negedge clk); check("R1 tick k3", tick_o, 1);
    @(negedge clk); check("R1 tick k4", tick_o, 0);
    issue(0, 0, 0, 1, 0); check("R9 flag clear", skip_o, 0);
    issue(0, 0, 1, 0, 0); check("R9 count zero", {rd_acc_o, rd_mem_o}, 0);
  endtask

  task automatic test_load_prescale();
    issue(1, 8'h35, 0, 0, 0);
    issue(0, 0, 1, 1, 0);
    check("R4 no flag low msb", skip_o, 0);
    check("R3 load value", {rd_acc_o, rd_mem_o}, 8'h35);
    wait_ticks(2);
    issue(0, 0, 1, 0, 0);
    check("R3 before first advance", {rd_acc_o, rd_mem_o}, 8'h35);
    issue(0, 0, 1, 0, 0);
    check("R2 advanced", {rd_acc_o, rd_mem_o}, 8'h36);
    wait_ticks(3);
    issue(0, 0, 1, 0, 0);
    check("R8 next advance", {rd_acc_o, rd_mem_o}, 8'h37);
  endtask

  task automatic test_load_msb();
    issue(1, 8'h80, 0, 0, 0);
    issue(0, 0, 0, 1, 0); check("R4 msb sets flag", skip_o, 1);
    @(negedge clk);        check("R6 skip one clock", skip_o, 0);
    issue(0, 0, 0, 1, 0); check("R6 flag cleared", skip_o, 0);
  endtask

  task automatic test_wrap();
    issue(1, 8'hFF, 0, 0, 0);
    issue(0, 0, 0, 1, 0);  // clears load-set flag
    issue(0, 0, 0, 1, 0); check("R6 clear stays clear", skip_o, 0);
    wait_ticks(1);
    issue(0, 0, 0, 0, 0);  // wrap tick
    issue(0, 0, 1, 1, 0);
    check("R5 wrap sets flag", skip_o, 1);
    check("R5 wrap to zero", {rd_acc_o, rd_mem_o}, 8'h00);
  endtask

  task automatic test_same_tick();
    issue(1, 8'hFF, 0, 0, 0);
    wait_ticks(3);
    issue(0, 0, 0, 1, 0); check("R7 skip on wrap tick", skip_o, 1);
    issue(0, 0, 0, 1, 0); check("R7 overflow wins", skip_o, 1);
    issue(0, 0, 0, 1, 0); check("R7 then cleared", skip_o, 0);
  endtask

  task automatic test_idle();
    int first = -1;
    int st0 = 0, st40 = 1, wk41 = 1;
    issue(1, 8'hFD, 0, 0, 0);
    issue(0, 0, 0, 1, 0);
    issue(0, 0, 0, 0, 1);
    for (int k = 0; k < 60; k++) begin
      if (k == 0) st0 = stall_o;
      if (k == 40) st40 = stall_o;
      if (k == 41) wk41 = wake_o;
      if (wake_o && first < 0) first = k;
      @(negedge clk);
    end
    check("R10 stall raised", st0, 1);
    check("R10 wake clock", first, 40);
    check("R10 stall dropped", st40, 0);
    check("R10 wake one clock", wk41, 0);
    issue(0, 0, 1, 1, 0);
    check("R10 overflow flag", skip_o, 1);
  endtask

  task automatic test_reset_midrun();
    issue(1, 8'h9A, 0, 0, 1);
    do_reset();
    check("R9 stall reset", stall_o, 0);
    issue(0, 0, 1, 1, 0);
    check("R9 flag reset", skip_o, 0);
    check("R9 count reset", {rd_acc_o, rd_mem_o}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset_state();
    test_load_prescale();
    test_load_msb();
    test_wrap();
    test_same_tick();
    test_idle();
    test_reset_midrun();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule